// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 16-bit successive-approximation converter. A host raises `sample` to acquire the input and lowers it to commit a conversion. The sequencer then drives the analog trial DAC through `dac_code` and reads the analog comparator on `cmp`, deciding one bit per rising edge of the externally supplied burst clock `clk`. At the same time it shifts the result out serially, MSB first, in two's complement, with a companion data strobe `dout_clk`. `busy` frames each conversion and each calibration.

`cal` is an asynchronous hard reset. While it is high everything is cleared and `busy` is held high. When it drops, a fixed-length calibration phase runs on `clk`. During that phase `sample` changes meaning: high forces `dout` low, and low routes a diagnostic bit to `dout`. The analog array and the correction arithmetic are outside the block; they are represented by the `cmp` input and by the parameter `CAL_LEN`.

Top module: `sar_seq_top`

## Requirements
- R1: While `cal` is high, and immediately after it rises, `busy` is 1, `dout` is 0 and `dac_code` is 0, whatever `clk` does. Raising `cal` in the middle of a conversion aborts that conversion.
- R2: After `cal` falls, `busy` stays high for exactly `CAL_LEN` rising `clk` edges and is low after the `CAL_LEN`-th edge.
- R3: After calibration edge j (counted from 1), `dout` is 0 if `sample` was high at that edge, and otherwise equals bit 0 of j.
- R4: Outside calibration and conversion, an edge that sees `sample` high arms the block. The next edge that sees `sample` low commits a conversion. That commit edge is edge 1 of the 17. After it, `busy` is 1 and `dac_code` holds only its MSB set (0x8000), and `dout` is unchanged.
- R5: Each of conversion edges 2 to 17 samples `cmp` to decide one bit, from bit 15 down to bit 0. The bit is kept when `cmp` is 1 and cleared when it is 0. The next lower bit is then set as the new trial. After edge 17, `dac_code` holds the final offset-binary code.
- R6: `busy` falls after the 17th conversion edge, so it is high for exactly 16 edge-to-edge intervals.
- R7: After conversion edge k (2 to 17), `dout` carries result bit 17-k of the two's complement result, which is the final code with its MSB inverted.
- R8: `sample` has no effect from the commit edge up to and including the 17th edge.
- R9: While `busy` is low and no new conversion is committed, `clk` edges change neither `dout` nor `dac_code`.
- R10: If `sample` is high at the edge on which `busy` falls, the block is armed at once, so the very next edge with `sample` low commits a new conversion.
- R11: `dout_clk` is the inverse of `clk` while `busy` is high and during the one clock period after `busy` falls. It is low otherwise and whenever `clk` is high. Its rising edges fall mid-cycle, after the `dout` update of the same cycle; the MSB is presented at its second pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Burst conversion clock; all state changes on its rising edge |
| cal | input | 1 | Asynchronous hard reset that starts calibration when it falls |
| sample | input | 1 | Acquire when high, commit on low; diagnostic select during calibration |
| cmp | input | 1 | Comparator result: 1 when the input is at or above `dac_code` |
| busy | output | 1 | High during calibration and conversion |
| dout | output | 1 | Serial result, two's complement, MSB first |
| dout_clk | output | 1 | Data strobe derived from `clk` |
| dac_code | output | NBITS | Current trial code for the analog DAC (offset binary) |

## Verification
Every registered result is due one rising edge after its cause. `busy` and `dac_code` are due after the commit edge, each decided bit on `dout` after the edge that sampled `cmp`, and the calibration end after edge `CAL_LEN`. The effect of `cal` is asynchronous and shows at once. The bench therefore advances its behavioural model on each rising edge, using the input values present at that edge. It compares all outputs 3 ns after the falling edge, when inputs are stable and the registered outputs have settled. `dout_clk` is checked in both clock phases, because it is the only combinational output.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        PH_CAL  = 2'd0,
        PH_IDLE = 2'd1,
        PH_ARM  = 2'd2,
        PH_CONV = 2'd3
    } sar_phase_e;

endpackage

// File: rtl/sar_code_step.sv
module sar_code_step #(
    parameter int NBITS = 16,
    parameter int CW    = 13
) (
    input  logic [NBITS-1:0] code_q,
    input  logic [CW-1:0]    step,
    input  logic             start,
    input  logic             cmp,
    output logic [NBITS-1:0] code_d
);
    // step s (1..NBITS) decides bit NBITS-s and proposes bit NBITS-s-1
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        localparam logic MSB_ONLY = (i == NBITS - 1);
        logic decide_here;
        logic trial_here;
        assign decide_here = (step == CW'(NBITS - i));
        assign trial_here  = (step == CW'(NBITS - 1 - i));
        assign code_d[i] = start       ? MSB_ONLY :
                           decide_here ? cmp      :
                           trial_here  ? 1'b1     : code_q[i];
    end
endmodule

// File: rtl/sar_strobe_gate.sv
module sar_strobe_gate (
    input  logic clk,
    input  logic run,
    output logic strobe
);
    // run only changes just after a rising clk edge, while clk is high,
    // so the product with the inverted clock cannot glitch
    assign strobe = ~clk & run;
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int NBITS   = 16,
    parameter int CAL_LEN = 4999
) (
    input  logic             clk,
    input  logic             cal,
    input  logic             sample,
    input  logic             cmp,
    output logic             busy,
    output logic             dout,
    output logic             dout_clk,
    output logic [NBITS-1:0] dac_code
);
    localparam int CW_CAL = $clog2(CAL_LEN + 1);
    localparam int CW_CNV = $clog2(NBITS + 2);
    localparam int CW     = (CW_CAL > CW_CNV) ? CW_CAL : CW_CNV;
    localparam logic [CW-1:0] CAL_LAST = CW'(CAL_LEN - 1);
    localparam logic [CW-1:0] CNV_LAST = CW'(NBITS);

    typedef struct packed {
        sar_phase_e       ph;
        logic [CW-1:0]    cnt;
        logic             busy;
        logic             tail;
        logic             dout;
        logic [NBITS-1:0] code;
    } seq_t;

    localparam seq_t SEQ_RST = '{ph: PH_CAL, cnt: '0, busy: 1'b1,
                                 tail: 1'b0, dout: 1'b0, code: '0};

    seq_t r_q, r_d;
    logic [NBITS-1:0] code_next_d;
    logic [CW-1:0]    cnt_inc_d;

    assign cnt_inc_d = r_q.cnt + 1'b1;

    sar_code_step #(.NBITS(NBITS), .CW(CW)) u_step (
        .code_q (r_q.code),
        .step   (r_q.cnt),
        .start  (r_q.ph == PH_ARM),
        .cmp    (cmp),
        .code_d (code_next_d)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.ph)
            PH_CAL: begin
                r_d.cnt  = cnt_inc_d;
                r_d.dout = sample ? 1'b0 : cnt_inc_d[0];
                if (r_q.cnt == CAL_LAST) begin
                    r_d.busy = 1'b0;
                    r_d.tail = 1'b1;
                    r_d.cnt  = '0;
                    r_d.ph   = sample ? PH_ARM : PH_IDLE;
                end
            end
            PH_IDLE: begin
                r_d.tail = 1'b0;
                if (sample) r_d.ph = PH_ARM;
            end
            PH_ARM: begin
                r_d.tail = 1'b0;
                if (!sample) begin
                    r_d.ph   = PH_CONV;
                    r_d.busy = 1'b1;
                    r_d.cnt  = CW'(1);
                    r_d.code = code_next_d;
                end
            end
            PH_CONV: begin
                r_d.cnt  = cnt_inc_d;
                r_d.code = code_next_d;
                r_d.dout = (r_q.cnt == CW'(1)) ? ~cmp : cmp;
                if (r_q.cnt == CNV_LAST) begin
                    r_d.busy = 1'b0;
                    r_d.tail = 1'b1;
                    r_d.cnt  = '0;
                    r_d.ph   = sample ? PH_ARM : PH_IDLE;
                end
            end
            default: r_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or posedge cal) begin
        if (cal) r_q <= SEQ_RST;
        else     r_q <= r_d;
    end

    sar_strobe_gate u_gate (
        .clk    (clk),
        .run    (r_q.busy | r_q.tail),
        .strobe (dout_clk)
    );

    assign busy     = r_q.busy;
    assign dout     = r_q.dout;
    assign dac_code = r_q.code;

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int NBITS   = 16,
    parameter int CAL_LEN = 4999
) (
    input logic             clk,
    input logic             cal,
    input logic             sample,
    input logic             busy,
    input logic             dout,
    input logic [NBITS-1:0] dac_code
);
    int   run_len;
    logic seen_idle;

    always_ff @(posedge clk or posedge cal) begin
        if (cal) begin
            run_len   <= 0;
            seen_idle <= 1'b0;
        end else begin
            run_len <= busy ? run_len + 1 : 0;
            if (!busy) seen_idle <= 1'b1;
        end
    end

    // R2
    cal_len_chk: assert property (@(posedge clk) disable iff (cal)
        ($fell(busy) && !seen_idle) |-> (run_len == CAL_LEN));

    // R6
    conv_len_chk: assert property (@(posedge clk) disable iff (cal)
        ($fell(busy) && seen_idle) |-> (run_len == NBITS));

    // R4
    commit_code_chk: assert property (@(posedge clk) disable iff (cal)
        $rose(busy) |-> (dac_code == {1'b1, {(NBITS-1){1'b0}}}));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (cal)
        (!$past(busy) && !busy) |-> ($stable(dout) && $stable(dac_code)));

    // R3
    diag_low_chk: assert property (@(posedge clk) disable iff (cal)
        ($past(busy) && !seen_idle && $past(sample)) |-> !dout);

endmodule

bind sar_seq_top sar_seq_chk #(.NBITS(NBITS), .CAL_LEN(CAL_LEN)) u_chk (
    .clk      (clk),
    .cal      (cal),
    .sample   (sample),
    .busy     (busy),
    .dout     (dout),
    .dac_code (dac_code)
);

// File: tb/test_sar_seq_top.sv
`timescale 1ns/1ps
module test_sar_seq_top;
    localparam int NB      = 16;
    localparam int CAL_LEN = 4999;

    logic clk = 1'b0;
    logic cal = 1'b1;
    logic sample = 1'b0;
    logic cmp;
    logic busy, dout, dout_clk;
    logic [NB-1:0] dac_code;
    logic [NB-1:0] vin = '0;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    // comparator stand-in for the analog input
    assign cmp = (dac_code <= vin);

    sar_seq_top #(.NBITS(NB), .CAL_LEN(CAL_LEN)) i_sar_seq_top (
        .clk(clk), .cal(cal), .sample(sample), .cmp(cmp),
        .busy(busy), .dout(dout), .dout_clk(dout_clk), .dac_code(dac_code)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_ph, m_cnt, m_code;
    bit m_busy, m_tail, m_dout;

    task automatic model_reset();
        m_ph = 0; m_cnt = 0; m_code = 0;
        m_busy = 1; m_tail = 0; m_dout = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (cal) model_reset();
        else begin
            case (m_ph)
                0: begin
                    m_cnt++;
                    m_dout = sample ? 1'b0 : bit'(m_cnt % 2);
                    if (m_cnt == CAL_LEN) begin
                        m_busy = 0; m_tail = 1; m_cnt = 0;
                        m_ph = sample ? 2 : 1;
                    end
                end
                1: begin
                    m_tail = 0;
                    if (sample) m_ph = 2;
                end
                2: begin
                    m_tail = 0;
                    if (!sample) begin
                        m_ph = 3; m_busy = 1; m_cnt = 1; m_code = 32768;
                    end
                end
                default: begin
                    int p;
                    p = NB - m_cnt;
                    m_cnt++;
                    if (!cmp) m_code = m_code & ~(1 << p);
                    if (p > 0) m_code = m_code | (1 << (p - 1));
                    m_dout = (p == NB - 1) ? !cmp : cmp;
                    if (p == 0) begin
                        m_busy = 0; m_tail = 1; m_cnt = 0;
                        m_ph = sample ? 2 : 1;
                    end
                end
            endcase
        end
    end

    // compare every cycle in the low phase, away from the edges
    always @(negedge clk) begin
        #3;
        if (cal) model_reset();
        check(busy == m_busy, (m_ph == 0) ? "R2" : "R6", busy, m_busy);
        check(dout == m_dout, (m_ph == 0) ? "R3" : "R7", dout, m_dout);
        check(int'(dac_code) == m_code, "R5", dac_code, m_code);
        check(dout_clk == (m_busy | m_tail), "R11", dout_clk, m_busy | m_tail);
    end

    always @(posedge clk) begin
        #2;
        check(dout_clk == 1'b0, "R11", dout_clk, 0);
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---------------- directed tasks ----------------
    task automatic run_cal();
        int n;
        @(negedge clk); cal = 1'b1; sample = 1'b0;
        #1;
        check(busy == 1'b1, "R1", busy, 1);
        check(dout == 1'b0, "R1", dout, 0);
        check(dac_code == '0, "R1", dac_code, 0);
        repeat (4) @(negedge clk);
        cal = 1'b0;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (!busy || n > CAL_LEN + 10) break;
            sample = ((n % 3) == 0) && (n < CAL_LEN - 2);
        end
        sample = 1'b0;
        check(n == CAL_LEN, "R2", n, CAL_LEN);
    endtask

    task automatic convert(input logic [NB-1:0] v, input bit wiggle, input bit hold_end);
        logic [NB-1:0] bits;
        bits = '0;
        vin = v;
        @(negedge clk); sample = 1'b1;
        @(negedge clk); sample = 1'b0;
        for (int k = 1; k <= NB + 1; k++) begin
            @(negedge clk);
            if (k == 1) begin
                check(busy == 1'b1, "R4", busy, 1);
                check(dac_code == 16'h8000, "R4", dac_code, 16'h8000);
            end else begin
                bits[NB + 1 - k] = dout;
            end
            if (wiggle && k < NB) sample = k[0]; // R8: must be ignored
            if (hold_end && k == NB) sample = 1'b1;
        end
        check(busy == 1'b0, "R6", busy, 0);
        check(dac_code == v, "R5", dac_code, v);
        check(bits == (v ^ 16'h8000), "R7", bits, v ^ 16'h8000);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [NB-1:0] held_code;
        logic          held_dout;

        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R1", busy, 1);
        check(dout == 1'b0, "R1", dout, 0);
        check(dac_code == '0, "R1", dac_code, 0);

        run_cal();

        convert(16'h1234, 1'b0, 1'b0);
        convert(16'h0000, 1'b0, 1'b0);
        convert(16'hFFFF, 1'b0, 1'b0);
        convert(16'h8000, 1'b0, 1'b0);
        convert(16'h7FFF, 1'b0, 1'b0);
        convert(16'hA5C3, 1'b1, 1'b0);   // R8 sample toggling mid-conversion

        // R9: stray clocks after completion
        held_code = dac_code;
        held_dout = dout;
        repeat (6) @(negedge clk);
        check(dac_code == held_code, "R9", dac_code, held_code);
        check(dout == held_dout, "R9", dout, held_dout);
        check(busy == 1'b0, "R9", busy, 0);

        // R10: sample high at the last edge arms immediately
        convert(16'h3C01, 1'b0, 1'b1);
        vin = 16'h0F0F;
        sample = 1'b0;
        @(negedge clk);
        check(busy == 1'b1, "R10", busy, 1);
        check(dac_code == 16'h8000, "R10", dac_code, 16'h8000);
        repeat (NB) @(negedge clk);
        check(busy == 1'b0, "R10", busy, 0);
        check(dac_code == 16'h0F0F, "R10", dac_code, 16'h0F0F);

        // R1: hard reset in the middle of a conversion
        vin = 16'h4444;
        @(negedge clk); sample = 1'b1;
        @(negedge clk); sample = 1'b0;
        repeat (6) @(negedge clk);
        run_cal();

        convert(16'h5A5A, 1'b0, 1'b0);
        repeat (3) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule